// File: doc/BRIEF.md
# PIO Timing Programming Sequencer

This block programs the programmed-I/O timing of one drive on a two-drive IDE channel. The controller's timing registers sit behind a locked configuration window. The block reaches that window through a one-access-at-a-time byte/word bus master port. A single `start` pulse captures four inputs: the target drive number, its PIO mode, the partner drive's mode and whether the partner exists.

The sequencer first probes the bus-clock select. It writes all-ones to offset 5 and keeps bit 0 of a word read back from the same offset. It then looks up two timing values in internal tables, both indexed by clock select and mode:

- a data/recovery value;
- an address-setup value. Both drives share the address-setup time, so this value is the slower (larger) of the two drives' requirements.

The block then performs five register writes. Each write is wrapped in its own unlock/relock envelope on the bus. After the last relock the block pulses `done` and goes back to idle.

Top module: `pio_timing_seq`

## Requirements
- R1: After an accepted start, the first access is a byte write of 0xFF to offset 5. The second is a word read from offset 5. Bit 0 of that read data is the clock select used for every table lookup.
- R2: Each register update takes five accesses in this order: a word read at offset 1, a second word read at offset 1, a byte write of 0x03 to offset 2, the register byte write, and a byte write of 0x83 to offset 2. A full run is exactly 27 accesses, and every read is a word access.
- R3: The five register writes go in this order:
  1. offset 6 receives the drive number;
  2. offset 0 receives the data/recovery value;
  3. offset 1 receives the same data/recovery value;
  4. offset 6 receives the address-setup value;
  5. offset 3 receives 0x85.
- R4: The data/recovery value for modes 0..4 is 0x6B, 0x56, 0x42, 0x32, 0x31 when the clock select is 0. It is 0x58, 0x44, 0x32, 0x22, 0x21 when the clock select is 1.
- R5: The address-setup value for modes 0..4 is 0x30, 0x20, 0x20, 0x10, 0x10 when the clock select is 0. It is 0x20, 0x20, 0x10, 0x10, 0x10 when the clock select is 1. When the partner is present, the value written is the larger of the target's entry and the partner's entry.
- R6: A target or partner mode above 4 is treated as mode 4.
- R7: `bus_req` stays high, and the access fields stay unchanged, until a cycle in which `bus_ack` is high. An access completes in the cycle where `bus_req` and `bus_ack` are both high.
- R8: A start pulse is ignored while a run is in progress. The run's accesses still follow the inputs captured at the accepted start, and no extra run follows.
- R9: `done` is high for exactly one cycle. That cycle is the one right after the cycle in which the final relock write completes, and `bus_req` is low in it.
- R10: Out of reset, `bus_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (ignored while busy) |
| drive_sel | input | 1 | Target drive number |
| pio_mode | input | 3 | Target PIO mode, clamped to 4 |
| partner_mode | input | 3 | Partner drive PIO mode, clamped to 4 |
| partner_present | input | 1 | Partner drive exists |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | 3 | Register offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completes this cycle |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| done | output | 1 | Run finished (one-cycle pulse) |

## Verification
Every access appears on the bus in the cycle after the previous access was acknowledged, and it holds there until acknowledged. The bench's responder therefore logs each access at the falling edge where it raises `bus_ack`. The read data it returns with the probe read takes effect in the next rising edge, and the table lookups use it from then on. `done` is due one cycle after the last acknowledge. The bench records the falling-edge index of both events and requires exactly that difference of one. It also confirms that `bus_req` is low a few cycles after `done`, which shows that no second run was started.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int MODE_W   = 3;
    localparam int MAX_MODE = 4;
    localparam int OFS_W    = 3;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int NUM_REGS = 5;
    localparam int ENV_LEN  = 5;

    // Offsets decoded by the configuration window
    localparam logic [OFS_W-1:0] OFS_RD_TIM  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_UNLOCKR = 3'd1;
    localparam logic [OFS_W-1:0] OFS_WR_TIM  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_LOCK    = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd3;
    localparam logic [OFS_W-1:0] OFS_CLKPRB  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MISC    = 3'd6;

    localparam logic [BYTE_W-1:0] VAL_UNLOCK = 8'h03;
    localparam logic [BYTE_W-1:0] VAL_RELOCK = 8'h83;
    localparam logic [BYTE_W-1:0] VAL_CTRL   = 8'h85;
    localparam logic [BYTE_W-1:0] VAL_PROBE  = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE_WR,
        ST_PROBE_RD,
        ST_ENV
    } seq_state_e;

    typedef struct packed {
        logic              we;
        logic              word;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] data;
    } bus_op_t;

    function automatic logic [MODE_W-1:0] clamp_mode(input logic [MODE_W-1:0] m);
        return (m > MODE_W'(MAX_MODE)) ? MODE_W'(MAX_MODE) : m;
    endfunction

    function automatic logic [BYTE_W-1:0] setup_entry(input logic ck,
                                                      input logic [MODE_W-1:0] m);
        logic [BYTE_W-1:0] v;
        case (m)
            3'd0:    v = ck ? 8'h20 : 8'h30;
            3'd1:    v = 8'h20;
            3'd2:    v = ck ? 8'h10 : 8'h20;
            default: v = 8'h10;
        endcase
        return v;
    endfunction

    function automatic logic [BYTE_W-1:0] recov_entry(input logic ck,
                                                      input logic [MODE_W-1:0] m);
        logic [BYTE_W-1:0] v;
        case (m)
            3'd0:    v = ck ? 8'h58 : 8'h6B;
            3'd1:    v = ck ? 8'h44 : 8'h56;
            3'd2:    v = ck ? 8'h32 : 8'h42;
            3'd3:    v = ck ? 8'h22 : 8'h32;
            default: v = ck ? 8'h21 : 8'h31;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pio_timing_lut.sv
module pio_timing_lut
    import pio_seq_pkg::*;
(
    input  logic              clk_sel,
    input  logic [MODE_W-1:0] own_mode,
    input  logic [MODE_W-1:0] pair_mode,
    input  logic              pair_valid,
    output logic [BYTE_W-1:0] recov_val,
    output logic [BYTE_W-1:0] setup_val
);
    logic [BYTE_W-1:0] own_setup;
    logic [BYTE_W-1:0] pair_setup;

    always_comb begin
        own_setup  = setup_entry(clk_sel, own_mode);
        pair_setup = setup_entry(clk_sel, pair_mode);
        recov_val  = recov_entry(clk_sel, own_mode);
        setup_val  = (pair_valid && (pair_setup > own_setup)) ? pair_setup : own_setup;
    end

    always_comb begin
        AST_SETUP_COVERS_PAIR: assert (!pair_valid || setup_val >= pair_setup); // R5
    end

endmodule

// File: rtl/pio_bus_op_gen.sv
module pio_bus_op_gen
    import pio_seq_pkg::*;
#(
    parameter int GRP_W = 3,
    parameter int PH_W  = 3
) (
    input  seq_state_e        state,
    input  logic [GRP_W-1:0]  grp,
    input  logic [PH_W-1:0]   ph,
    input  logic              drive,
    input  logic [BYTE_W-1:0] recov_val,
    input  logic [BYTE_W-1:0] setup_val,
    output bus_op_t           op
);
    bus_op_t reg_op;

    // Register payload chosen by group index; order is part of the behaviour
    always_comb begin
        reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_MISC, data: BYTE_W'(drive)};
        case (grp)
            3'd0: reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_MISC,   data: BYTE_W'(drive)};
            3'd1: reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_RD_TIM, data: recov_val};
            3'd2: reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_WR_TIM, data: recov_val};
            3'd3: reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_MISC,   data: setup_val};
            default: reg_op = '{we: 1'b1, word: 1'b0, ofs: OFS_CTRL, data: VAL_CTRL};
        endcase
    end

    always_comb begin
        op = '{we: 1'b0, word: 1'b0, ofs: '0, data: '0};
        case (state)
            ST_PROBE_WR: op = '{we: 1'b1, word: 1'b0, ofs: OFS_CLKPRB, data: VAL_PROBE};
            ST_PROBE_RD: op = '{we: 1'b0, word: 1'b1, ofs: OFS_CLKPRB, data: '0};
            ST_ENV: begin
                case (ph)
                    3'd0, 3'd1: op = '{we: 1'b0, word: 1'b1, ofs: OFS_UNLOCKR, data: '0};
                    3'd2:       op = '{we: 1'b1, word: 1'b0, ofs: OFS_LOCK, data: VAL_UNLOCK};
                    3'd3:       op = reg_op;
                    default:    op = '{we: 1'b1, word: 1'b0, ofs: OFS_LOCK, data: VAL_RELOCK};
                endcase
            end
            default: ;
        endcase
    end

    always_comb begin
        AST_READS_ARE_WORD: assert (op.we || op.word || state == ST_IDLE); // R2
    end

endmodule

// File: rtl/pio_timing_seq.sv
module pio_timing_seq
    import pio_seq_pkg::*;
#(
    parameter int GRP_W = 3,
    parameter int PH_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               drive_sel,
    input  logic [2:0]         pio_mode,
    input  logic [2:0]         partner_mode,
    input  logic               partner_present,
    output logic               bus_req,
    output logic               bus_we,
    output logic               bus_word,
    output logic [2:0]         bus_addr,
    output logic [7:0]         bus_wdata,
    input  logic               bus_ack,
    input  logic [15:0]        bus_rdata,
    output logic               done
);
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_REGS - 1);
    localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(ENV_LEN - 1);

    seq_state_e        state_q;
    logic [GRP_W-1:0]  grp_q;
    logic [PH_W-1:0]   ph_q;
    logic              drive_q;
    logic [MODE_W-1:0] mode_q;
    logic [MODE_W-1:0] pmode_q;
    logic              pvalid_q;
    logic              clk_sel_q;
    logic              done_q;
    logic              xfer;
    logic [BYTE_W-1:0] recov_val;
    logic [BYTE_W-1:0] setup_val;
    bus_op_t           op;

    assign xfer = bus_req && bus_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            grp_q     <= '0;
            ph_q      <= '0;
            drive_q   <= 1'b0;
            mode_q    <= '0;
            pmode_q   <= '0;
            pvalid_q  <= 1'b0;
            clk_sel_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        drive_q  <= drive_sel;
                        mode_q   <= clamp_mode(pio_mode);
                        pmode_q  <= clamp_mode(partner_mode);
                        pvalid_q <= partner_present;
                        grp_q    <= '0;
                        ph_q     <= '0;
                        state_q  <= ST_PROBE_WR;
                    end
                end
                ST_PROBE_WR: if (xfer) state_q <= ST_PROBE_RD;
                ST_PROBE_RD: begin
                    if (xfer) begin
                        clk_sel_q <= bus_rdata[0];
                        state_q   <= ST_ENV;
                    end
                end
                default: begin
                    if (xfer) begin
                        if (ph_q == LAST_PH) begin
                            ph_q <= '0;
                            if (grp_q == LAST_GRP) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                grp_q <= grp_q + 1'b1;
                            end
                        end else begin
                            ph_q <= ph_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    pio_timing_lut u_lut (
        .clk_sel    (clk_sel_q),
        .own_mode   (mode_q),
        .pair_mode  (pmode_q),
        .pair_valid (pvalid_q),
        .recov_val  (recov_val),
        .setup_val  (setup_val)
    );

    pio_bus_op_gen #(.GRP_W(GRP_W), .PH_W(PH_W)) u_opgen (
        .state     (state_q),
        .grp       (grp_q),
        .ph        (ph_q),
        .drive     (drive_q),
        .recov_val (recov_val),
        .setup_val (setup_val),
        .op        (op)
    );

    assign bus_req   = (state_q != ST_IDLE);
    assign bus_we    = op.we;
    assign bus_word  = op.word;
    assign bus_addr  = op.ofs;
    assign bus_wdata = op.data;
    assign done      = done_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_word)
                                   && $stable(bus_addr) && $stable(bus_wdata))); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_AFTER_RELOCK: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_req && bus_ack && bus_we && bus_addr == OFS_LOCK
                       && bus_wdata == VAL_RELOCK)); // R9
    AST_REQ_DROP_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> done); // R9
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_req && start) |=> ($stable(drive_q) && $stable(mode_q)
                                && $stable(pmode_q) && $stable(pvalid_q))); // R8
    AST_MODE_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (mode_q <= MODE_W'(MAX_MODE) && pmode_q <= MODE_W'(MAX_MODE))); // R6

endmodule

// File: tb/pio_timing_seq_tb.sv
`timescale 1ns/1ps
module pio_timing_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        drive_sel = 1'b0;
    logic [2:0]  pio_mode = '0;
    logic [2:0]  partner_mode = '0;
    logic        partner_present = 1'b0;
    logic        bus_req, bus_we, bus_word, done;
    logic [2:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = '0;

    always #2 clk = ~clk;

    pio_timing_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .drive_sel(drive_sel),
        .pio_mode(pio_mode), .partner_mode(partner_mode),
        .partner_present(partner_present), .bus_req(bus_req), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Responder state
    int cyc = 0;
    int lat = 0;
    int wcnt = 0;
    bit clk_bit = 0;
    int nops = 0;
    int last_ack_cyc = 0;
    int done_cnt = 0;
    int done_cyc = 0;
    logic       log_we   [0:39];
    logic       log_word [0:39];
    logic [2:0] log_addr [0:39];
    logic [7:0] log_data [0:39];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst || bus_ack) begin
                bus_ack = 1'b0;
                wcnt = 0;
            end else if (bus_req) begin
                if (wcnt >= lat) begin
                    if (nops < 40) begin
                        log_we[nops]   = bus_we;
                        log_word[nops] = bus_word;
                        log_addr[nops] = bus_addr;
                        log_data[nops] = bus_wdata;
                    end
                    nops++;
                    bus_rdata = (bus_addr == 3'd5) ? (16'hBEE0 | 16'(clk_bit)) : 16'h1356;
                    bus_ack = 1'b1;
                    last_ack_cyc = cyc;
                end else begin
                    wcnt++;
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    function automatic int exp_setup(input bit c, input int m);
        int t0 [5] = '{48, 32, 32, 16, 16};
        int t1 [5] = '{32, 32, 16, 16, 16};
        return c ? t1[m] : t0[m];
    endfunction

    function automatic int exp_recov(input bit c, input int m);
        int t0 [5] = '{107, 86, 66, 50, 49};
        int t1 [5] = '{88, 68, 50, 34, 33};
        return c ? t1[m] : t0[m];
    endfunction

    task automatic run(input bit c, input bit drv, input int m, input int pm,
                       input bit pp, input int latency, input bit intrude);
        int mc, pmc, ea, er, done0, w;
        string sfx;
        mc  = (m > 4) ? 4 : m;
        pmc = (pm > 4) ? 4 : pm;
        ea  = exp_setup(c, mc);
        if (pp && exp_setup(c, pmc) > ea) ea = exp_setup(c, pmc);
        er  = exp_recov(c, mc);
        sfx = ((m > 4) || (pp && pm > 4)) ? " R6" : "";
        @(negedge clk);
        clk_bit = c; lat = latency; nops = 0; done0 = done_cnt;
        drive_sel = drv; pio_mode = 3'(m); partner_mode = 3'(pm); partner_present = pp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (9) @(negedge clk);
            drive_sel = ~drv; pio_mode = 3'(5 - mc); partner_mode = 3'd0;
            partner_present = ~pp; clk_bit = ~c;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (done_cnt == done0 && w < 3000) begin @(negedge clk); w++; end
        repeat (6) @(negedge clk);
        check(nops == 27, "R2 access count", nops, 27);
        check(done_cnt - done0 == 1, intrude ? "R8 done pulses" : "R9 done pulses",
              done_cnt - done0, 1);
        check(done_cyc == last_ack_cyc + 1, "R9 done timing", done_cyc - last_ack_cyc, 1);
        check(bus_req == 1'b0, intrude ? "R8 idle after run" : "R9 idle after run",
              int'(bus_req), 0);
        if (nops == 27) begin
            for (int i = 0; i < 27; i++) begin
                int eo, ed, g, p;
                bit ew, ewd;
                string tg;
                if (i == 0) begin ew = 1; ewd = 0; eo = 5; ed = 255; tg = "R1"; end
                else if (i == 1) begin ew = 0; ewd = 1; eo = 5; ed = 0; tg = "R1"; end
                else begin
                    g = (i - 2) / 5; p = (i - 2) % 5;
                    if (p < 2) begin ew = 0; ewd = 1; eo = 1; ed = 0; tg = "R2"; end
                    else if (p == 2) begin ew = 1; ewd = 0; eo = 2; ed = 3; tg = "R2"; end
                    else if (p == 4) begin ew = 1; ewd = 0; eo = 2; ed = 131; tg = "R2"; end
                    else begin
                        ew = 1; ewd = 0;
                        case (g)
                            0: begin eo = 6; ed = drv;  tg = "R3"; end
                            1: begin eo = 0; ed = er;   tg = {"R4", sfx}; end
                            2: begin eo = 1; ed = er;   tg = {"R4", sfx}; end
                            3: begin eo = 6; ed = ea;   tg = {"R5", sfx}; end
                            default: begin eo = 3; ed = 133; tg = "R3"; end
                        endcase
                    end
                end
                check(log_we[i] == ew && log_word[i] == ewd && int'(log_addr[i]) == eo,
                      $sformatf("%s kind/offset op%0d (R3 order)", tg, i),
                      {log_we[i], log_word[i], log_addr[i]}, {ew, ewd, 3'(eo)});
                if (ew)
                    check(int'(log_data[i]) == ed, $sformatf("%s data op%0d", tg, i),
                          log_data[i], ed);
            end
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(bus_req == 1'b0, "R10 req in reset", bus_req, 0);
        check(done == 1'b0, "R10 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(bus_req == 1'b0 && done == 1'b0, "R10 idle after reset",
              {bus_req, done}, 0);
        for (int c = 0; c < 2; c++)
            for (int m = 0; m < 6; m++)
                for (int pm = -1; pm < 6; pm++)
                    run(c[0], m[0] ^ c[0], m, (pm < 0) ? 0 : pm, pm >= 0,
                        (m + pm + 1) % 3, ((m + pm) % 7) == 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule